// File: doc/BRIEF.md
# Mode-Switchable Signed/Unsigned Array Multiplier

This block multiplies two equal-width operands with no clock and no storage. The product settles after the carries have rippled through a grid of half-adder and full-adder cells, one row of cells per multiplier bit. A single mode input picks the operand interpretation at run time. When it is low, both operands are unsigned and the result is their exact unsigned product. When it is high, both operands are two's-complement numbers and the result is their exact two's-complement product. The same cell array serves both modes.

Signed operation uses a sign-correction scheme rather than separate hardware. The mode input inverts every partial-product bit that pairs exactly one operand sign bit with a non-sign bit. It also adds a one at weight WIDTH and another at weight 2*WIDTH-1. The first one enters as the carry into the first adder row. The second one is folded into the top product bit. In unsigned mode both corrections are off, and the array becomes a plain carry-ripple multiplier.

A surrounding unit selects this block when its multiply/divide choice is "multiply". Operand capture, result multiplexing and any pipelining belong to that unit and not to this block.

Top module: `mulArray`

## Requirements
- R1: With signedMode = 0, product equals the unsigned product of multiplier and multiplicand for every pair of WIDTH-bit operands.
- R2: With signedMode = 1, product equals the 2*WIDTH-bit two's-complement product of the two operands, each read as two's complement (bit WIDTH-1 is the sign), for every pair.
- R3: The same operand bits give different results in the two modes where the interpretations differ. For example, 0xFF times 0xFF gives 0xFE01 unsigned and 0x0001 signed.
- R4: If either operand is zero, product is zero in both modes. This includes the state right after power-up with both operands held at zero.
- R5: The signed extremes are exact: 0x80 times 0x80 gives 0x4000, and 0x80 times 0x7F gives 0xC080.
- R6: The block holds no state. product follows a change of operands or mode within the same clock cycle of the surrounding logic, with no cycle of latency.
- R7: In signed mode with both operands non-zero, product bit 2*WIDTH-1 equals the XOR of the two operand sign bits.
- R8: In unsigned mode, product never exceeds (2^WIDTH-1)^2, which is 0xFE01 for WIDTH = 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| multiplier | input | WIDTH (8) | First operand; each bit drives one adder row |
| multiplicand | input | WIDTH (8) | Second operand; each bit drives one column of every row |
| signedMode | input | 1 | 0 = unsigned operands, 1 = two's-complement operands |
| product | output | 2*WIDTH (16) | Exact product of the two operands in the selected mode |

## Verification
Every operand pair is applied in unsigned mode and then again in signed mode, so any misplaced or missing partial-product bit shows up. A missing inversion or correction one appears only in signed mode, which separates a fault in the sign-correction path from a fault in the adder grid. Directed cases come first:
- all-ones operands, to contrast the two modes;
- zero operands;
- the most negative value times itself and times the most positive value;
- mixed-sign pairs.

Consecutive operands change on every cycle, which would expose any hidden register in the path.

// File: rtl/mulArrayPkg.sv
package mulArrayPkg;

  // Strobes from the mode decode to the adder grid.
  typedef struct packed {
    logic invertEdge;  // flip partial products pairing one sign bit with a non-sign bit
    logic injectOnes;  // add the two correction ones (weights W and 2W-1)
  } mulStrobes_t;

endpackage

// File: rtl/mulHalfAdder.sv
module mulHalfAdder (
  input  logic x,
  input  logic y,
  output logic sum,
  output logic co
);

  always_comb begin
    sum = x ^ y;
    co  = x & y;
    if (!$isunknown({x, y}))
      p_ha_total_r1: assert ({co, sum} == (2'(x) + 2'(y)))
        else $error("half adder cell mis-sums");
  end

endmodule

// File: rtl/mulFullAdder.sv
module mulFullAdder (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic sum,
  output logic co
);

  always_comb begin
    sum = x ^ y ^ ci;
    co  = (x & y) | (ci & (x ^ y));
    if (!$isunknown({x, y, ci}))
      p_fa_total_r2: assert ({co, sum} == (2'(x) + 2'(y) + 2'(ci)))
        else $error("full adder cell mis-sums");
  end

endmodule

// File: rtl/mulModeCtrl.sv
module mulModeCtrl
  import mulArrayPkg::*;
(
  input  logic        signedMode,
  output mulStrobes_t strobes
);

  // Signed mode needs both the edge inversion and the correction ones;
  // unsigned mode needs neither.
  always_comb begin
    strobes.invertEdge = signedMode;
    strobes.injectOnes = signedMode;
  end

endmodule

// File: rtl/mulArrayDatapath.sv
module mulArrayDatapath
  import mulArrayPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   aIn,
  input  logic [WIDTH-1:0]   bIn,
  input  mulStrobes_t        strobes,
  output logic [2*WIDTH-1:0] product
);

  localparam int PW = 2 * WIDTH;
  localparam int TOP = WIDTH - 1;
  localparam logic [PW-1:0] MAX_UNSIGNED = PW'((2**WIDTH - 1) * (2**WIDTH - 1));

  // pp[r][c]: multiplier bit r times multiplicand bit c, weight r+c.
  logic [WIDTH-1:0][WIDTH-1:0] pp;

  always_comb begin
    for (int r = 0; r < WIDTH; r++) begin
      for (int c = 0; c < WIDTH; c++) begin
        pp[r][c] = (aIn[r] & bIn[c]) ^
                   (strobes.invertEdge & ((r == TOP) ^ (c == TOP)));
      end
    end
  end

  assign product[0] = pp[0][0];

  // Row r (1..WIDTH-1) adds pp[r] to the shifted running sum of the rows above.
  for (genvar r = 1; r < WIDTH; r++) begin : gRow
    for (genvar c = 0; c < WIDTH; c++) begin : gCol
      logic xBit;
      logic s;
      logic co;

      // Running-sum input at weight r+c.
      if (r == 1) begin : gFirst
        if (c == TOP) begin : gEdge
          assign xBit = strobes.injectOnes;  // correction one at weight WIDTH
        end else begin : gMid
          assign xBit = pp[0][c+1];
        end
      end else begin : gLater
        if (c == TOP) begin : gEdge
          assign xBit = gRow[r-1].gCol[TOP].co;
        end else begin : gMid
          assign xBit = gRow[r-1].gCol[c+1].s;
        end
      end

      if (c == 0) begin : gHalf
        mulHalfAdder uHa (.x(xBit), .y(pp[r][c]), .sum(s), .co(co));
      end else begin : gFull
        mulFullAdder uFa (.x(xBit), .y(pp[r][c]), .ci(gCol[c-1].co), .sum(s), .co(co));
      end

      if (r < TOP && c == 0) begin : gLowOut
        assign product[r] = s;
      end
      if (r == TOP) begin : gHighOut
        assign product[TOP + c] = s;
      end
    end
  end

  // Top bit: last carry plus the correction one at weight 2*WIDTH-1.
  assign product[PW-1] = gRow[TOP].gCol[TOP].co ^ strobes.injectOnes;

  always_comb begin
    if (!$isunknown({aIn, bIn, strobes, product})) begin
      if (aIn == '0 || bIn == '0)
        p_zero_operand_r4: assert (product == '0)
          else $error("zero operand gave non-zero product");
      if (strobes.invertEdge && aIn != '0 && bIn != '0)
        p_sign_rule_r7: assert (product[PW-1] == (aIn[TOP] ^ bIn[TOP]))
          else $error("signed product has wrong sign");
      if (!strobes.invertEdge)
        p_no_overflow_r8: assert (product <= MAX_UNSIGNED)
          else $error("unsigned product above bound");
    end
  end

endmodule

// File: rtl/mulArray.sv
module mulArray
  import mulArrayPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]   multiplier,
  input  logic [WIDTH-1:0]   multiplicand,
  input  logic               signedMode,
  output logic [2*WIDTH-1:0] product
);

  mulStrobes_t strobes;

  mulModeCtrl uCtrl (
    .signedMode (signedMode),
    .strobes    (strobes)
  );

  mulArrayDatapath #(.WIDTH(WIDTH)) uPath (
    .aIn     (multiplier),
    .bIn     (multiplicand),
    .strobes (strobes),
    .product (product)
  );

endmodule

// File: tb/tb_mulArray.sv
`timescale 1ns/1ps
module tb_mulArray;

  localparam int W = 8;
  localparam int PW = 2 * W;
  localparam int WATCHDOG_CYCLES = 190000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]  multiplier = '0;
  logic [W-1:0]  multiplicand = '0;
  logic          signedMode = 1'b0;
  logic [PW-1:0] product;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [W-1:0]  a;
    logic [W-1:0]  b;
    logic          sm;
    logic [PW-1:0] expProd;
    string         tag;
  } item_t;

  item_t sbQueue[$];

  always #2 clk = ~clk;  // 4 ns period

  mulArray #(.WIDTH(W)) dut (
    .multiplier   (multiplier),
    .multiplicand (multiplicand),
    .signedMode   (signedMode),
    .product      (product)
  );

  function automatic logic [PW-1:0] refProd(logic [W-1:0] x, logic [W-1:0] y, logic s);
    if (s)
      return PW'($signed({{W{x[W-1]}}, x}) * $signed({{W{y[W-1]}}, y}));
    return {{W{1'b0}}, x} * {{W{1'b0}}, y};
  endfunction

  // Driver: applies operands at a rising edge and queues the expectation.
  task automatic drive(input logic [W-1:0] x, input logic [W-1:0] y,
                       input logic s, input string tag);
    item_t it;
    @(posedge clk);
    multiplier   <= x;
    multiplicand <= y;
    signedMode   <= s;
    it.a = x; it.b = y; it.sm = s; it.expProd = refProd(x, y, s); it.tag = tag;
    sbQueue.push_back(it);
  endtask

  // Directed item with an explicit expected value taken from a requirement.
  task automatic driveFixed(input logic [W-1:0] x, input logic [W-1:0] y,
                            input logic s, input logic [PW-1:0] e, input string tag);
    item_t it;
    @(posedge clk);
    multiplier   <= x;
    multiplicand <= y;
    signedMode   <= s;
    it.a = x; it.b = y; it.sm = s; it.expProd = e; it.tag = tag;
    sbQueue.push_back(it);
  endtask

  // Monitor: compares at the falling edge of the same cycle (no latency, R6).
  always @(negedge clk) begin
    if (!rst && sbQueue.size() != 0) begin
      item_t it;
      it = sbQueue.pop_front();
      checks++;
      if (product !== it.expProd) begin
        fails++;
        $display("FAIL %s a=%h b=%h signed=%b actual=%h expected=%h",
                 it.tag, it.a, it.b, it.sm, product, it.expProd);
      end
    end
  end

  task automatic finish();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish();
    end
  end

  initial begin
    // Reset state: operands held at zero give a zero product (R4).
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (product !== '0) begin
      fails++;
      $display("FAIL R4 reset state actual=%h expected=%h", product, {PW{1'b0}});
    end
    @(posedge clk);
    rst = 1'b0;

    // R3: identical bits, two interpretations.
    driveFixed(8'hFF, 8'hFF, 1'b0, 16'hFE01, "R3 unsigned all-ones");
    driveFixed(8'hFF, 8'hFF, 1'b1, 16'h0001, "R3 signed all-ones");
    // R4: zero operands.
    driveFixed(8'h00, 8'h80, 1'b1, 16'h0000, "R4 zero times min");
    driveFixed(8'hA5, 8'h00, 1'b0, 16'h0000, "R4 zero multiplicand");
    // R5: signed extremes.
    driveFixed(8'h80, 8'h80, 1'b1, 16'h4000, "R5 min times min");
    driveFixed(8'h80, 8'h7F, 1'b1, 16'hC080, "R5 min times max");
    // R7: mixed signs.
    driveFixed(8'hFD, 8'h05, 1'b1, 16'hFFF1, "R7 minus3 times 5");
    driveFixed(8'hF9, 8'hFA, 1'b1, 16'h002A, "R7 minus7 times minus6");
    // R8: the unsigned bound value itself.
    driveFixed(8'hFF, 8'hFF, 1'b0, 16'hFE01, "R8 unsigned max");
    // R6: operands and mode change every cycle.
    driveFixed(8'h12, 8'h34, 1'b0, 16'h03A8, "R6 back-to-back 1");
    driveFixed(8'h81, 8'h02, 1'b1, 16'hFF02, "R6 back-to-back 2");
    driveFixed(8'h81, 8'h02, 1'b0, 16'h0102, "R6 back-to-back 3");

    // R1 and R2: every pair in each mode.
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        drive(8'(i), 8'(j), 1'b0, "R1");
    for (int i = 0; i < 256; i++)
      for (int j = 0; j < 256; j++)
        drive(8'(i), 8'(j), 1'b1, "R2");

    @(posedge clk);
    while (sbQueue.size() != 0) @(posedge clk);
    @(posedge clk);
    finished = 1'b1;
    finish();
  end

endmodule